// File: doc/BRIEF.md
# Next-Line Fetch Predictor

This block sits beside the instruction fetch unit of a machine that fetches aligned groups of 2, 4 or 8 instructions per cycle. For every fetch line it keeps one stored pointer that says both whether control leaves the line early and, if so, which line and which slot fetch goes to next. The pointer is read out in step with the line, so a single structure stands in for separate direction and target predictors.

A lookup presents the current fetch line address and the slot where fetch entered that line. One clock later the block returns the predicted next line, the slot at which that next line will be entered, the slot at which control leaves the current line, and a per-slot valid mask that clears the slots skipped before the entry point and the slots fetched after a taken branch (keeping one delay slot when that option is built in). When the back end finds a wrong prediction it writes the corrected pointer for the offending line through the update port.

The table is direct-mapped on the low line-address bits with no tags, so lines that share those bits share an entry. From reset every entry predicts plain sequential flow.

Top module: `nlp_fetch_predictor`

## Requirements
- R1: After reset every entry predicts sequential flow: next line = lookup line + 1 (wrapping modulo 2^LINE_AW), next entry slot 0, pr_taken low, pr_exit = GROUP-1.
- R2: pr_valid is high in exactly the cycle after a cycle with lk_valid high, and the other outputs belong to that lookup; results come out in lookup order.
- R3: A lookup that hits an entry written with upd_taken high returns pr_taken high and the stored next line, next entry slot and exit slot.
- R4: An update is applied at the clock edge that samples it; a lookup sampled at any later edge sees the new contents, including a rewrite back to sequential flow (upd_taken low).
- R5: When a lookup and an update address the same entry in the same cycle, the lookup returns the contents from before the update.
- R6: The entry is chosen only by the low IDX_W bits of lk_line; lines that differ only in higher bits read the same stored pointer, while sequential flow still adds one to the full lookup line.
- R7: pr_mask bit i stands for slot i of the looked-up line; bits below lk_off are clear.
- R8: With DELAY_SLOT = 0, a taken entry clears every mask bit above its exit slot; a sequential entry keeps every bit from lk_off to GROUP-1.
- R9: With DELAY_SLOT = 1, a taken entry also keeps the slot just after its exit slot, capped at slot GROUP-1.
- R10: When lk_off lies above the last kept slot, pr_mask is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_line | input | LINE_AW | Line address of the current fetch group |
| lk_off | input | SLOT_W | Slot where fetch enters this line |
| upd_valid | input | 1 | Write a corrected pointer this cycle |
| upd_idx | input | IDX_W | Table entry of the mispredicted line |
| upd_taken | input | 1 | Control leaves the line early (0 = sequential) |
| upd_next_line | input | LINE_AW | Corrected next line address |
| upd_next_off | input | SLOT_W | Corrected entry slot in the next line |
| upd_exit | input | SLOT_W | Slot of the taken branch in the line |
| pr_valid | output | 1 | Prediction outputs are valid |
| pr_taken | output | 1 | Predicted to leave the line early |
| pr_next_line | output | LINE_AW | Predicted next fetch line |
| pr_next_off | output | SLOT_W | Predicted entry slot in the next line |
| pr_exit | output | SLOT_W | Last slot of the current line before leaving |
| pr_mask | output | GROUP | Per-slot valid mask of the current line |

## Verification
Two instances, one without and one with the delay slot, run on the same stimulus so each mask pattern shows whether the extra slot is kept and capped. Lookups straight after reset, including the top line address, separate sequential wrap from stored pointers; a lookup colliding with an update on the same entry separates old-before-new ordering from write-through; an aliased line with different upper bits shows that no tag is compared. Entry offsets of zero, mid-group and past the exit slot, against exits at the first, middle and last slot, tell apart the lower and upper edges of the mask and the empty case, and a back-to-back stream over mixed entries checks ordering and one-cycle latency.

// File: rtl/nlp_pkg.sv
package nlp_pkg;

  typedef enum logic {
    FLOW_SEQ  = 1'b0,
    FLOW_JUMP = 1'b1
  } flow_e;

  function automatic bit group_ok(input int g);
    return (g == 2) || (g == 4) || (g == 8);
  endfunction

endpackage

// File: rtl/nlp_rst_sync.sv
module nlp_rst_sync (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_out_n = stage_q[1];

endmodule

// File: rtl/nlp_ptr_table.sv
module nlp_ptr_table #(
  parameter int LINE_AW = 12,
  parameter int IDX_W   = 4,
  parameter int SLOT_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic               rd_taken,
  output logic [LINE_AW-1:0] rd_line,
  output logic [SLOT_W-1:0]  rd_off,
  output logic [SLOT_W-1:0]  rd_exit,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic               wr_taken,
  input  logic [LINE_AW-1:0] wr_line,
  input  logic [SLOT_W-1:0]  wr_off,
  input  logic [SLOT_W-1:0]  wr_exit
);

  localparam int DEPTH = 1 << IDX_W;
  localparam int ENT_W = 1 + LINE_AW + 2 * SLOT_W;

  logic [ENT_W-1:0] word_all [DEPTH];
  logic [ENT_W-1:0] wr_word;
  logic [ENT_W-1:0] rd_d;
  logic [ENT_W-1:0] rd_q;
  logic [DEPTH-1:0] wr_sel;

  always_comb begin
    wr_word = {wr_taken, wr_line, wr_off, wr_exit};
    wr_sel  = '0;
    if (wr_en) begin
      wr_sel[wr_idx] = 1'b1;
    end
    rd_d = word_all[rd_idx];
  end

  generate
    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic [ENT_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          word_q <= '0;
        end else if (wr_sel[e]) begin
          word_q <= wr_word;
        end
      end
      assign word_all[e] = word_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_q <= rd_d;
    end
  end

  assign {rd_taken, rd_line, rd_off, rd_exit} = rd_q;

  p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> word_all[$past(wr_idx)] == $past(wr_word))
    else $error("update did not land in its entry");

endmodule

// File: rtl/nlp_slot_mask.sv
module nlp_slot_mask #(
  parameter int GROUP      = 4,
  parameter int SLOT_W     = 2,
  parameter bit DELAY_SLOT = 1'b0
) (
  input  logic              leaves,
  input  logic [SLOT_W-1:0] entry_off,
  input  logic [SLOT_W-1:0] exit_slot,
  output logic [GROUP-1:0]  mask
);

  localparam logic [SLOT_W:0] LAST = (SLOT_W + 1)'(GROUP - 1);

  logic [SLOT_W:0] stretched;
  logic [SLOT_W:0] stop_slot;
  logic [SLOT_W:0] start_slot;

  generate
    if (DELAY_SLOT) begin : g_delay
      assign stretched = {1'b0, exit_slot} + (SLOT_W + 1)'(1);
    end else begin : g_plain
      assign stretched = {1'b0, exit_slot};
    end
  endgenerate

  always_comb begin
    start_slot = {1'b0, entry_off};
    if (!leaves) begin
      stop_slot = LAST;
    end else if (stretched > LAST) begin
      stop_slot = LAST;
    end else begin
      stop_slot = stretched;
    end
  end

  generate
    for (genvar s = 0; s < GROUP; s++) begin : g_slot
      localparam logic [SLOT_W:0] SIDX = (SLOT_W + 1)'(s);
      assign mask[s] = (SIDX >= start_slot) && (SIDX <= stop_slot);
    end
  endgenerate

endmodule

// File: rtl/nlp_fetch_predictor.sv
module nlp_fetch_predictor
  import nlp_pkg::*;
#(
  parameter int LINE_AW    = 12,
  parameter int IDX_W      = 4,
  parameter int GROUP      = 4,
  parameter bit DELAY_SLOT = 1'b0,
  parameter int SLOT_W     = $clog2(GROUP)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_valid,
  input  logic [LINE_AW-1:0] lk_line,
  input  logic [SLOT_W-1:0]  lk_off,
  input  logic               upd_valid,
  input  logic [IDX_W-1:0]   upd_idx,
  input  logic               upd_taken,
  input  logic [LINE_AW-1:0] upd_next_line,
  input  logic [SLOT_W-1:0]  upd_next_off,
  input  logic [SLOT_W-1:0]  upd_exit,
  output logic               pr_valid,
  output logic               pr_taken,
  output logic [LINE_AW-1:0] pr_next_line,
  output logic [SLOT_W-1:0]  pr_next_off,
  output logic [SLOT_W-1:0]  pr_exit,
  output logic [GROUP-1:0]   pr_mask
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(GROUP - 1);

  generate
    if (!group_ok(GROUP) || (IDX_W > LINE_AW)) begin : g_bad_cfg
      $error("fetch group must be 2, 4 or 8 and IDX_W must not exceed LINE_AW");
    end
  endgenerate

  logic rst_sync_n;

  nlp_rst_sync u_rst (
    .clk      (clk),
    .rst_in_n (rst_n),
    .rst_out_n(rst_sync_n)
  );

  logic               ent_taken;
  logic [LINE_AW-1:0] ent_line;
  logic [SLOT_W-1:0]  ent_off;
  logic [SLOT_W-1:0]  ent_exit;

  nlp_ptr_table #(
    .LINE_AW(LINE_AW),
    .IDX_W  (IDX_W),
    .SLOT_W (SLOT_W)
  ) u_table (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rd_en   (lk_valid),
    .rd_idx  (lk_line[IDX_W-1:0]),
    .rd_taken(ent_taken),
    .rd_line (ent_line),
    .rd_off  (ent_off),
    .rd_exit (ent_exit),
    .wr_en   (upd_valid),
    .wr_idx  (upd_idx),
    .wr_taken(upd_taken),
    .wr_line (upd_next_line),
    .wr_off  (upd_next_off),
    .wr_exit (upd_exit)
  );

  // lookup context held alongside the table read
  logic               q_valid, q_valid_d;
  logic [LINE_AW-1:0] q_line, q_line_d;
  logic [SLOT_W-1:0]  q_off, q_off_d;

  always_comb begin
    q_valid_d = lk_valid;
    q_line_d  = lk_line;
    q_off_d   = lk_off;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      q_valid <= 1'b0;
    end else begin
      q_valid <= q_valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (lk_valid) begin
      q_line <= q_line_d;
      q_off  <= q_off_d;
    end
  end

  flow_e flow;
  assign flow = ent_taken ? FLOW_JUMP : FLOW_SEQ;

  always_comb begin
    pr_valid = q_valid;
    if (flow == FLOW_JUMP) begin
      pr_taken     = 1'b1;
      pr_next_line = ent_line;
      pr_next_off  = ent_off;
      pr_exit      = ent_exit;
    end else begin
      pr_taken     = 1'b0;
      pr_next_line = q_line + LINE_AW'(1);
      pr_next_off  = '0;
      pr_exit      = LAST_SLOT;
    end
  end

  nlp_slot_mask #(
    .GROUP     (GROUP),
    .SLOT_W    (SLOT_W),
    .DELAY_SLOT(DELAY_SLOT)
  ) u_mask (
    .leaves   (pr_taken),
    .entry_off(q_off),
    .exit_slot(pr_exit),
    .mask     (pr_mask)
  );

  p_result_follows_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    lk_valid |=> pr_valid)
    else $error("lookup produced no result");

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !lk_valid |=> !pr_valid)
    else $error("result without a lookup");

  p_first_slot_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pr_valid |-> (pr_mask[0] == (q_off == '0)))
    else $error("slot zero mask disagrees with entry offset");

  p_seq_tail_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pr_valid && !pr_taken && (pr_mask != '0)) |-> pr_mask[GROUP-1])
    else $error("sequential line lost its last slot");

  p_mask_no_gap_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pr_valid |-> ($countones(pr_mask ^ (pr_mask >> 1)) <= 2))
    else $error("mask is not one contiguous run");

endmodule

// File: tb/test_nlp_fetch_predictor.sv
`timescale 1ns/1ps
module test_nlp_fetch_predictor;

  localparam int LINE_AW = 12;
  localparam int IDX_W   = 4;
  localparam int GROUP   = 4;
  localparam int SLOT_W  = 2;

  typedef struct packed {
    logic               taken;
    logic [LINE_AW-1:0] nline;
    logic [SLOT_W-1:0]  noff;
    logic [SLOT_W-1:0]  ext;
    logic [GROUP-1:0]   mask0;
    logic [GROUP-1:0]   mask1;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  always #4 clk = ~clk;

  logic               lk_valid = 1'b0;
  logic [LINE_AW-1:0] lk_line = '0;
  logic [SLOT_W-1:0]  lk_off = '0;
  logic               upd_valid = 1'b0;
  logic [IDX_W-1:0]   upd_idx = '0;
  logic               upd_taken = 1'b0;
  logic [LINE_AW-1:0] upd_next_line = '0;
  logic [SLOT_W-1:0]  upd_next_off = '0;
  logic [SLOT_W-1:0]  upd_exit = '0;

  logic               a_valid, b_valid, a_taken, b_taken;
  logic [LINE_AW-1:0] a_line, b_line;
  logic [SLOT_W-1:0]  a_noff, b_noff, a_exit, b_exit;
  logic [GROUP-1:0]   a_mask, b_mask;

  nlp_fetch_predictor #(.LINE_AW(LINE_AW), .IDX_W(IDX_W), .GROUP(GROUP), .DELAY_SLOT(1'b0))
  i_nlp_fetch_predictor (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_line(lk_line), .lk_off(lk_off),
    .upd_valid(upd_valid), .upd_idx(upd_idx), .upd_taken(upd_taken),
    .upd_next_line(upd_next_line), .upd_next_off(upd_next_off), .upd_exit(upd_exit),
    .pr_valid(a_valid), .pr_taken(a_taken), .pr_next_line(a_line),
    .pr_next_off(a_noff), .pr_exit(a_exit), .pr_mask(a_mask));

  nlp_fetch_predictor #(.LINE_AW(LINE_AW), .IDX_W(IDX_W), .GROUP(GROUP), .DELAY_SLOT(1'b1))
  i_nlp_fetch_predictor_ds (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_line(lk_line), .lk_off(lk_off),
    .upd_valid(upd_valid), .upd_idx(upd_idx), .upd_taken(upd_taken),
    .upd_next_line(upd_next_line), .upd_next_off(upd_next_off), .upd_exit(upd_exit),
    .pr_valid(b_valid), .pr_taken(b_taken), .pr_next_line(b_line),
    .pr_next_off(b_noff), .pr_exit(b_exit), .pr_mask(b_mask));

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;

  exp_t  q_exp[$];
  string q_tag[$];

  bit               m_taken [1 << IDX_W];
  logic [LINE_AW-1:0] m_line [1 << IDX_W];
  logic [SLOT_W-1:0]  m_off  [1 << IDX_W];
  logic [SLOT_W-1:0]  m_exit [1 << IDX_W];

  function automatic logic [GROUP-1:0] window(input logic [SLOT_W-1:0] off, input bit tk,
                                              input logic [SLOT_W-1:0] ex, input bit ds);
    logic [GROUP-1:0] w;
    int last;
    last = tk ? (int'(ex) + (ds ? 1 : 0)) : GROUP - 1;
    if (last > GROUP - 1) last = GROUP - 1;
    for (int i = 0; i < GROUP; i++) w[i] = (i >= int'(off)) && (i <= last);
    return w;
  endfunction

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
  endtask

  // one bus cycle: expected result from the model, then the model update, then the pins
  task automatic step(input bit lv, input logic [LINE_AW-1:0] line, input logic [SLOT_W-1:0] off,
                      input bit uv, input logic [IDX_W-1:0] uidx, input bit utk,
                      input logic [LINE_AW-1:0] uline, input logic [SLOT_W-1:0] uoff,
                      input logic [SLOT_W-1:0] uex, input string tag);
    exp_t e;
    int ix;
    @(negedge clk);
    if (lv) begin
      ix = int'(line[IDX_W-1:0]);
      e.taken = m_taken[ix];
      if (m_taken[ix]) begin
        e.nline = m_line[ix];
        e.noff  = m_off[ix];
        e.ext   = m_exit[ix];
      end else begin
        e.nline = line + LINE_AW'(1);
        e.noff  = '0;
        e.ext   = SLOT_W'(GROUP - 1);
      end
      e.mask0 = window(off, e.taken, e.ext, 1'b0);
      e.mask1 = window(off, e.taken, e.ext, 1'b1);
      q_exp.push_back(e);
      q_tag.push_back(tag);
    end
    if (uv) begin
      m_taken[int'(uidx)] = utk;
      m_line[int'(uidx)]  = uline;
      m_off[int'(uidx)]   = uoff;
      m_exit[int'(uidx)]  = uex;
    end
    lk_valid = lv; lk_line = line; lk_off = off;
    upd_valid = uv; upd_idx = uidx; upd_taken = utk;
    upd_next_line = uline; upd_next_off = uoff; upd_exit = uex;
  endtask

  task automatic look(input logic [LINE_AW-1:0] line, input logic [SLOT_W-1:0] off, input string tag);
    step(1'b1, line, off, 1'b0, '0, 1'b0, '0, '0, '0, tag);
  endtask

  task automatic write(input logic [IDX_W-1:0] idx, input bit tk, input logic [LINE_AW-1:0] nl,
                       input logic [SLOT_W-1:0] no, input logic [SLOT_W-1:0] ex);
    step(1'b0, '0, '0, 1'b1, idx, tk, nl, no, ex, "");
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1'b0, '0, '0, 1'b0, '0, 1'b0, '0, '0, '0, "");
  endtask

  // monitor: pop one expected item for every result cycle
  always @(negedge clk) begin
    if (mon_on && (a_valid || b_valid)) begin
      if (q_exp.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R2 result with no lookup: actual valid=%b/%b expected=0/0", a_valid, b_valid);
      end else begin
        exp_t e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        n_checks++;
        if (!a_valid || a_taken !== e.taken || a_line !== e.nline || a_noff !== e.noff ||
            a_exit !== e.ext || a_mask !== e.mask0) begin
          n_fail++;
          $display("FAIL %s plain: actual v=%b t=%b line=%h off=%0d exit=%0d mask=%b expected v=1 t=%b line=%h off=%0d exit=%0d mask=%b",
                   t, a_valid, a_taken, a_line, a_noff, a_exit, a_mask, e.taken, e.nline, e.noff, e.ext, e.mask0);
        end
        n_checks++;
        if (!b_valid || b_taken !== e.taken || b_line !== e.nline || b_noff !== e.noff ||
            b_exit !== e.ext || b_mask !== e.mask1) begin
          n_fail++;
          $display("FAIL %s delay: actual v=%b t=%b line=%h off=%0d exit=%0d mask=%b expected v=1 t=%b line=%h off=%0d exit=%0d mask=%b",
                   t, b_valid, b_taken, b_line, b_noff, b_exit, b_mask, e.taken, e.nline, e.noff, e.ext, e.mask1);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL R2 watchdog expired: actual cycles=%0d expected below 20000", cyc);
      report();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1 << IDX_W); i++) begin
      m_taken[i] = 1'b0; m_line[i] = '0; m_off[i] = '0; m_exit[i] = '0;
    end
    #1 rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // reset state: no result pending (R1, R2)
    n_checks++;
    if (a_valid !== 1'b0 || b_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset valid: actual=%b/%b expected=0/0", a_valid, b_valid);
    end
    mon_on = 1'b1;

    look(12'h005, 2'd0, "R1 sequential full mask");
    look(12'hFFF, 2'd2, "R1 R7 wrap and entry slot");
    // update idx 3 and look up an aliasing line of idx 3 in the same cycle
    step(1'b1, 12'h023, 2'd0, 1'b1, 4'd3, 1'b1, 12'h2A0, 2'd1, 2'd1, "R5 old value on collision");
    look(12'h013, 2'd0, "R3 R4 R8 R9 stored pointer");
    look(12'h7F3, 2'd1, "R6 alias high bits ignored");
    write(4'd5, 1'b1, 12'h100, 2'd3, 2'd3);
    look(12'h015, 2'd2, "R9 delay slot capped at group end");
    write(4'd7, 1'b1, 12'h040, 2'd0, 2'd0);
    look(12'h037, 2'd2, "R10 entry after exit gives empty mask");
    look(12'h037, 2'd0, "R8 R9 exit at slot zero");
    write(4'd3, 1'b0, 12'h000, 2'd0, 2'd0);
    look(12'h013, 2'd3, "R4 rewrite to sequential");
    idle(2);
    for (int k = 0; k < 8; k++) look(LINE_AW'(12'h100 + k), SLOT_W'(k % 4), "R2 back-to-back stream");
    idle(3);

    n_checks++;
    if (q_exp.size() != 0) begin
      n_fail++;
      $display("FAIL R2 missing results: actual pending=%0d expected=0", q_exp.size());
    end
    done = 1'b1;
    report();
    $finish;
  end

endmodule